// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface. On a start request it writes the device's extended mode register and then its base mode register, in that order. Each write is a single-cycle command on the chip-select, row-strobe, column-strobe, write-enable, bank and address pins. Before it issues anything, the block checks the requested burst length code and CAS latency code against the small set the device accepts. It also checks that all banks report idle and that the clock-enable is already high.

The extended register contents come in as a ready-made address word. The base register word is assembled inside the block from the burst length, burst type, CAS latency and DLL-reset inputs. After each register write the block holds the pins at NOP for a parameterised number of cycles. It then reports completion through a level `done`. A request that fails any check puts nothing on the command pins and sets a sticky error flag, which stays set until the next start.

Top module: `ddr_mrs_seq`

## Requirements
- R1: After reset the pins carry NOP (chip-select low; row, column and write strobes high), the bank and address outputs are zero, and busy, done and err are low. Bank bit 1 is never driven high.
- R2: One cycle after an accepted start is sampled, the pins carry a register write (all four strobes low) with bank = 2'b01 and address = the extended word that was sampled with start. Busy is high from that cycle.
- R3: Exactly GAP_CYC cycles after the extended write, a base write appears with bank = 2'b00. Its address has burst length code on bits 2..0, burst type on bit 3 (0 sequential, 1 interleave), CAS latency code on bits 6..4, DLL reset on bit 8, and zero on bit 7 and on every bit above 8.
- R4: In every cycle that carries no register write, the pins carry NOP. No two writes are less than GAP_CYC cycles apart.
- R5: GAP_CYC cycles after the base write, busy falls and done rises in the same cycle. Done then stays high until the next start is sampled.
- R6: Only burst length codes 3'b001, 3'b010 and 3'b011 are accepted. Any other code rejects the request.
- R7: Only CAS latency codes 3'b011 and 3'b110 are accepted. Any other code rejects the request.
- R8: A start sampled while banks-idle is low or clock-enable is low is rejected. A rejected start, for any reason, issues no write, keeps busy low and clears done. It sets err, which holds until the next start is sampled; that next start clears err whether or not it is accepted.
- R9: A start sampled while busy is ignored.
- R10: The mode inputs are captured when start is accepted. Changing them during the sequence does not alter the base word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to program both registers |
| banks_idle_i | input | 1 | All banks precharged and idle |
| cke_i | input | 1 | Clock-enable currently high |
| bl_code_i | input | 3 | Burst length code |
| burst_il_i | input | 1 | Burst type, 1 = interleave |
| cl_code_i | input | 3 | CAS latency code |
| dll_rst_i | input | 1 | Request DLL reset |
| ext_word_i | input | ADDR_W | Extended register contents |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address / register select |
| addr_o | output | ADDR_W | Address pins |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Both registers written and final gap elapsed |
| err_o | output | 1 | Sticky rejection flag |

## Verification
The bench sweeps every burst length code, every latency code, both burst types and both DLL-reset values, and follows each request cycle by cycle. A design that accepted a reserved code, such as the latency code next to the half-cycle one, would put a write on the pins where only NOP is expected. A design that checked the codes but dropped the bank-idle or clock-enable condition would issue writes on a rejected request. The bench also scrambles the mode inputs and pulses start while a sequence is running. A design that read the inputs live would emit a wrong base word, and one that accepted a start while busy would restart early. The bench also checks that err clears on the next start and that done holds until then; a flag that cleared itself too early or too late would fail those checks.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;
  localparam int BA_W = 2;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam logic [BA_W-1:0] SEL_BASE = 2'b00;
  localparam logic [BA_W-1:0] SEL_EXT  = 2'b01;

  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int DLL_BIT = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP_EXT, ST_GAP_BASE} seq_state_t;
endpackage

// File: rtl/mrs_code_check.sv
module mrs_code_check (
  input  logic [2:0] bl_code_i,
  input  logic [2:0] cl_code_i,
  output logic       legal_o
);
  logic bl_ok, cl_ok;

  always_comb begin
    unique case (bl_code_i)
      3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
      default:                bl_ok = 1'b0;
    endcase
    unique case (cl_code_i)
      3'b011, 3'b110: cl_ok = 1'b1;
      default:        cl_ok = 1'b0;
    endcase
  end

  assign legal_o = bl_ok & cl_ok;
endmodule

// File: rtl/mrs_word_build.sv
module mrs_word_build
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        bl_code_i,
  input  logic              burst_il_i,
  input  logic [2:0]        cl_code_i,
  input  logic              dll_rst_i,
  output logic [ADDR_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    word_o[BL_LSB +: 3] = bl_code_i;
    word_o[BT_BIT]      = burst_il_i;
    word_o[CL_LSB +: 3] = cl_code_i;
    word_o[DLL_BIT]     = dll_rst_i;
  end
endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(GAP_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(GAP_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              banks_idle_i,
  input  logic              cke_i,
  input  logic [2:0]        bl_code_i,
  input  logic              burst_il_i,
  input  logic [2:0]        cl_code_i,
  input  logic              dll_rst_i,
  input  logic [ADDR_W-1:0] ext_word_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_t        state_q;
  ddr_cmd_t          cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_word;
  logic              codes_legal, accept, gap_done, timer_load;

  mrs_code_check code_chk_i (
    .bl_code_i (bl_code_i),
    .cl_code_i (cl_code_i),
    .legal_o   (codes_legal)
  );

  mrs_word_build #(.ADDR_W(ADDR_W)) word_i (
    .bl_code_i  (bl_code_i),
    .burst_il_i (burst_il_i),
    .cl_code_i  (cl_code_i),
    .dll_rst_i  (dll_rst_i),
    .word_o     (base_word)
  );

  mrs_gap_timer #(.GAP_CYC(GAP_CYC)) gap_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (timer_load),
    .expired_o (gap_done)
  );

  assign accept     = (state_q == ST_IDLE) && start_i && codes_legal && banks_idle_i && cke_i;
  assign timer_load = accept || ((state_q == ST_GAP_EXT) && gap_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            done_o <= 1'b0;
            if (accept) begin
              err_o   <= 1'b0;
              cmd_q   <= CMD_MRS;
              ba_q    <= SEL_EXT;
              addr_q  <= ext_word_i;
              base_q  <= base_word;
              busy_o  <= 1'b1;
              state_q <= ST_GAP_EXT;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_GAP_EXT: begin
          if (gap_done) begin
            cmd_q   <= CMD_MRS;
            ba_q    <= SEL_BASE;
            addr_q  <= base_q;
            state_q <= ST_GAP_BASE;
          end
        end
        ST_GAP_BASE: begin
          if (gap_done) begin
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o  = cmd_q.cs_n;
  assign ras_n_o = cmd_q.ras_n;
  assign cas_n_o = cmd_q.cas_n;
  assign we_n_o  = cmd_q.we_n;
  assign ba_o    = ba_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/ddr_mrs_seq_chk.sv
module ddr_mrs_seq_chk #(
  parameter int ADDR_W  = 12,
  parameter int GAP_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic              err
);
  localparam int CW = $clog2(GAP_CYC + 2) + 1;
  localparam logic [CW-1:0] SAT = CW'(GAP_CYC + 1);

  logic is_wr, is_nop, is_ext, is_base;
  logic [CW-1:0] since_ext, since_base;

  assign is_wr   = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_nop  = !cs_n && ras_n && cas_n && we_n;
  assign is_ext  = is_wr && (ba == 2'b01);
  assign is_base = is_wr && (ba == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ext  <= '0;
      since_base <= '0;
    end else begin
      if (is_ext)                                   since_ext <= CW'(1);
      else if (since_ext != '0 && since_ext != SAT) since_ext <= since_ext + 1'b1;
      if (is_base)                                    since_base <= CW'(1);
      else if (since_base != '0 && since_base != SAT) since_base <= since_base + 1'b1;
    end
  end

  // R1
  ba_hi_zero_chk: assert property (@(posedge clk) disable iff (rst) !ba[1]);
  // R4
  pins_nop_or_wr_chk: assert property (@(posedge clk) disable iff (rst) is_wr || is_nop);
  // R4
  wr_then_nop_chk: assert property (@(posedge clk) disable iff (rst) is_wr |=> is_nop);
  // R2
  ext_busy_chk: assert property (@(posedge clk) disable iff (rst) is_ext |-> busy && !done && !err);
  // R3
  base_spacing_chk: assert property (@(posedge clk) disable iff (rst) is_base |-> since_ext == CW'(GAP_CYC));
  // R3
  base_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    is_base |-> (addr >> 9) == '0 && !addr[7]);
  // R6
  base_bl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    is_base |-> addr[2:0] inside {3'b001, 3'b010, 3'b011});
  // R7
  base_cl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    is_base |-> addr[6:4] inside {3'b011, 3'b110});
  // R5
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> since_base == CW'(GAP_CYC) && !busy);
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst) err |-> !busy && !done);
endmodule

bind ddr_mrs_seq ddr_mrs_seq_chk #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n_o),
  .ras_n (ras_n_o),
  .cas_n (cas_n_o),
  .we_n  (we_n_o),
  .ba    (ba_o),
  .addr  (addr_o),
  .busy  (busy_o),
  .done  (done_o),
  .err   (err_o)
);

// File: tb/ddr_mrs_seq_tb_top.sv
module ddr_mrs_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int G  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, idle = 1'b1, cke = 1'b1, bt = 1'b0, dll = 1'b0;
  logic [2:0] bl = 3'd1, cl = 3'd3;
  logic [AW-1:0] ext = '0;
  logic cs_n, ras_n, cas_n, we_n, busy, done, err;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_mrs_seq #(.ADDR_W(AW), .GAP_CYC(G)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .banks_idle_i(idle), .cke_i(cke),
    .bl_code_i(bl), .burst_il_i(bt), .cl_code_i(cl), .dll_rst_i(dll), .ext_word_i(ext),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .busy_o(busy), .done_o(done), .err_o(err)
  );

  localparam int VW = 4 + 2 + AW + 3;

  task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [VW-1:0] pack_nop(input logic b, input logic d, input logic e);
    return {4'b0111, 2'b00, {AW{1'b0}}, b, d, e};
  endfunction

  task automatic run_case(input logic [2:0] rbl, input logic rbt, input logic [2:0] rcl,
                          input logic rdll, input logic ridle, input logic rcke,
                          input logic [AW-1:0] rext, input logic mid_start);
    logic codes_ok, pre_ok, ok;
    logic [AW-1:0] base_exp;
    logic [VW-1:0] exp;
    string tag;
    codes_ok = (rbl >= 3'd1 && rbl <= 3'd3) && (rcl == 3'd3 || rcl == 3'd6);
    pre_ok   = ridle && rcke;
    ok       = codes_ok && pre_ok;
    base_exp = {3'b000, rdll, 1'b0, rcl, rbt, rbl};
    bl = rbl; bt = rbt; cl = rcl; dll = rdll; idle = ridle; cke = rcke; ext = rext;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bl = ~rbl; cl = ~rcl; bt = ~rbt; dll = ~rdll; ext = ~rext;
    for (int c = 1; c <= 2*G + 1; c++) begin
      if (c > 1) @(negedge clk);
      if (!ok) begin
        if (!pre_ok) tag = "R8";
        else if (!(rbl >= 3'd1 && rbl <= 3'd3)) tag = "R6 R8";
        else tag = "R7 R8";
        exp = pack_nop(1'b0, 1'b0, 1'b1);
      end else if (c == 1) begin
        tag = "R2"; exp = {4'b0000, 2'b01, rext, 1'b1, 1'b0, 1'b0};
      end else if (c == G + 1) begin
        tag = "R3 R10"; exp = {4'b0000, 2'b00, base_exp, 1'b1, 1'b0, 1'b0};
      end else if (c == 2*G + 1) begin
        tag = "R5"; exp = pack_nop(1'b0, 1'b1, 1'b0);
      end else begin
        tag = mid_start ? "R4 R9" : "R4"; exp = pack_nop(1'b1, 1'b0, 1'b0);
      end
      check(tag, {cs_n, ras_n, cas_n, we_n, ba, addr, busy, done, err}, exp);
      if (mid_start && c == 2) begin start = 1'b1; bl = 3'd0; end
      if (c == 3) start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {cs_n, ras_n, cas_n, we_n, ba, addr, busy, done, err}, pack_nop(1'b0, 1'b0, 1'b0));

    for (int b = 0; b < 8; b++)
      for (int l = 0; l < 8; l++)
        for (int t = 0; t < 2; t++)
          for (int d = 0; d < 2; d++)
            run_case(3'(b), t[0], 3'(l), d[0], 1'b1, 1'b1,
                     AW'(12'hA50 ^ (b << 8) ^ (l << 4) ^ (t << 2) ^ d), ((b + l) % 3) == 0);

    // R8 precondition failures with legal codes, then recovery clears err
    run_case(3'd2, 1'b0, 3'd6, 1'b0, 1'b0, 1'b1, 12'h123, 1'b0);
    run_case(3'd3, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 12'h456, 1'b0);
    run_case(3'd1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 12'hFFF, 1'b0);

    // R5 done holds until next start
    repeat (3) @(negedge clk);
    check("R5", {cs_n, ras_n, cas_n, we_n, ba, addr, busy, done, err}, pack_nop(1'b0, 1'b1, 1'b0));

    // R8 a rejected start clears done
    run_case(3'd0, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 12'h0F0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule